// File: doc/BRIEF.md
# Dual-Modulus Swallow-Counter Frequency Divider

This block turns a fast oscillator clock into the comparison-rate pulse of a frequency synthesizer. It also turns a crystal clock into the matching reference-rate pulse.

On the oscillator side there are three counters. A prescaler divides by 32 or 33. A 5-bit swallow counter decides how many divide-by-33 cycles occur in each output period. An 11-bit main counter counts prescaler outputs. Together they give an overall ratio of 32·(B+1)+A. On the crystal side, a reference counter divides by R+1.

The program word and the reference divide value are plain, quasi-static control levels. They carry no handshake and apply no back-pressure. Each domain samples its own value only at the boundary of its own output period, so a period in progress is never cut short. The program word belongs to the oscillator domain and the divide value to the crystal domain. Software is expected to change them no faster than one output period of the respective side.

Top module: `dms_synth_divider`

## Requirements
- R1: `syn_pulse` is high for exactly one oscillator cycle per synthesizer period. It is low in every other cycle.
- R2: The program word carries the swallow value A in bits 4:0 and the main value B in bits 15:5. A legal program gives a synthesizer period of 32·(B+1)+A oscillator cycles. The first A prescaler cycles of a period last 33 oscillator cycles and the remaining ones last 32.
- R3: After reset is released, the first synthesizer period is 32 oscillator cycles, as if A=0 and B=0. The program word is adopted in the cycle that ends that period.
- R4: A new A and B are adopted only in the oscillator cycle where `syn_pulse` is high. A program change inside a period leaves that period's length unchanged.
- R5: A program word with A > B is never adopted, and the last legal A and B stay in use. `prog_err` rises at the first oscillator edge that samples such a word. It then stays high until reset.
- R6: `ref_pulse` is high for one crystal cycle once every R+1 crystal cycles. R is `ref_div`, and R=0 makes it high in every cycle.
- R7: After reset is released, the first reference period is 2 crystal cycles. A new R is adopted only in the crystal cycle where `ref_pulse` is high.
- R8: While reset is asserted, `syn_pulse`, `ref_pulse` and `prog_err` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Fast oscillator clock being divided |
| xtal_clk | input | 1 | Crystal clock for the reference side |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| prog_word | input | 16 | Program word: A in bits 4:0, B in bits 15:5 (oscillator domain) |
| ref_div | input | 10 | Reference divide value R (crystal domain) |
| syn_pulse | output | 1 | One-cycle pulse per synthesizer period (oscillator domain) |
| ref_pulse | output | 1 | One-cycle pulse per reference period (crystal domain) |
| prog_err | output | 1 | Sticky flag for an illegal A > B program (oscillator domain) |

## Verification
`syn_pulse` and `ref_pulse` are decoded from counter state, so each pulse appears in the last cycle of its period. A changed program or divide value first affects the period that starts at the edge after that pulse. `prog_err` follows an illegal word at the first rising edge that samples it.

The bench holds a cycle-count model for each clock domain. It advances the model on the same rising edge as the design and compares all outputs at the falling edge. Each expectation is therefore read a half cycle after the edge that produced it. Inputs change one nanosecond after a rising edge, so every edge sees a settled value.

// File: rtl/dms_pkg.sv
`timescale 1ns/1ps
package dms_pkg;
  typedef enum logic {
    MOD_LOW  = 1'b0,
    MOD_HIGH = 1'b1
  } pre_mode_t;
endpackage

// File: rtl/dms_prescaler.sv
`timescale 1ns/1ps
module dms_prescaler #(
  parameter int A_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dms_pkg::pre_mode_t mode,
  output logic              pre_last
);
  localparam logic [A_W:0] PRE_BASE = (A_W+1)'(1) << A_W;

  logic [A_W:0] pre_cnt;
  logic [A_W:0] pre_top;

  assign pre_top  = (mode == dms_pkg::MOD_HIGH) ? PRE_BASE : PRE_BASE - (A_W+1)'(1);
  assign pre_last = (pre_cnt == pre_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_cnt <= '0;
    else if (pre_last) pre_cnt <= '0;
    else               pre_cnt <= pre_cnt + (A_W+1)'(1);
  end

  assert_pre_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= PRE_BASE);
endmodule

// File: rtl/dms_period_ctl.sv
`timescale 1ns/1ps
module dms_period_ctl #(
  parameter int A_W = 5,
  parameter int B_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [A_W-1:0]     prog_a,
  input  logic [B_W-1:0]     prog_b,
  input  logic               pre_last,
  output dms_pkg::pre_mode_t mode,
  output logic               period_end,
  output logic               err
);
  logic [A_W-1:0] a_act;
  logic [B_W-1:0] b_act;
  logic [A_W-1:0] swl_cnt;
  logic [B_W-1:0] main_cnt;
  logic           legal;

  assign legal      = (B_W'(prog_a) <= prog_b);
  assign mode       = (swl_cnt != '0) ? dms_pkg::MOD_HIGH : dms_pkg::MOD_LOW;
  assign period_end = pre_last && (main_cnt == b_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_act    <= '0;
      b_act    <= '0;
      swl_cnt  <= '0;
      main_cnt <= '0;
      err      <= 1'b0;
    end else begin
      err <= err | ~legal;
      if (period_end) begin
        main_cnt <= '0;
        if (legal) begin
          a_act   <= prog_a;
          b_act   <= prog_b;
          swl_cnt <= prog_a;
        end else begin
          swl_cnt <= a_act;
        end
      end else if (pre_last) begin
        main_cnt <= main_cnt + B_W'(1);
        if (swl_cnt != '0) swl_cnt <= swl_cnt - A_W'(1);
      end
    end
  end

  assert_legal_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    B_W'(a_act) <= b_act);
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_prog_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> ($stable(a_act) && $stable(b_act)));
  assert_syn_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !period_end);
endmodule

// File: rtl/dms_ref_divider.sv
`timescale 1ns/1ps
module dms_ref_divider #(
  parameter int R_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [R_W-1:0] ref_div,
  output logic           ref_pulse
);
  logic [R_W-1:0] r_act;
  logic [R_W-1:0] rc;

  assign ref_pulse = (rc == r_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_act <= R_W'(1);
      rc    <= '0;
    end else if (ref_pulse) begin
      r_act <= ref_div;
      rc    <= '0;
    end else begin
      rc <= rc + R_W'(1);
    end
  end

  assert_ref_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_pulse |=> $stable(r_act));
  assert_ref_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rc <= r_act);
endmodule

// File: rtl/dms_synth_divider.sv
`timescale 1ns/1ps
module dms_synth_divider #(
  parameter int A_W = 5,
  parameter int B_W = 11,
  parameter int R_W = 10,
  localparam int P_W = A_W + B_W
) (
  input  logic           osc_clk,
  input  logic           xtal_clk,
  input  logic           rst_n,
  input  logic [P_W-1:0] prog_word,
  input  logic [R_W-1:0] ref_div,
  output logic           syn_pulse,
  output logic           ref_pulse,
  output logic           prog_err
);
  dms_pkg::pre_mode_t mode;
  logic               pre_last;

  dms_prescaler #(.A_W(A_W)) u_pre (
    .clk      (osc_clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .pre_last (pre_last)
  );

  dms_period_ctl #(.A_W(A_W), .B_W(B_W)) u_ctl (
    .clk        (osc_clk),
    .rst_n      (rst_n),
    .prog_a     (prog_word[A_W-1:0]),
    .prog_b     (prog_word[P_W-1:A_W]),
    .pre_last   (pre_last),
    .mode       (mode),
    .period_end (syn_pulse),
    .err        (prog_err)
  );

  dms_ref_divider #(.R_W(R_W)) u_ref (
    .clk       (xtal_clk),
    .rst_n     (rst_n),
    .ref_div   (ref_div),
    .ref_pulse (ref_pulse)
  );

  assert_reset_quiet_R8: assert property (@(posedge osc_clk)
    !rst_n |-> (!syn_pulse && !prog_err));
endmodule

// File: tb/dms_synth_divider_test.sv
`timescale 1ns/1ps
module dms_synth_divider_test;
  logic        osc_clk = 1'b0;
  logic        xtal_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] prog_word = '0;
  logic [9:0]  ref_div = '0;
  logic        syn_pulse, ref_pulse, prog_err;

  int    vectors = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string osc_tag = "R8";
  string ref_tag = "R8";

  // Oscillator-side model state
  int k = 0;
  int n_cur = 32;
  bit err_m = 1'b0;
  // Crystal-side model state
  int j = 0;
  int r_cur = 1;

  dms_synth_divider uut (
    .osc_clk(osc_clk), .xtal_clk(xtal_clk), .rst_n(rst_n),
    .prog_word(prog_word), .ref_div(ref_div),
    .syn_pulse(syn_pulse), .ref_pulse(ref_pulse), .prog_err(prog_err)
  );

  always #2.5 osc_clk = ~osc_clk;
  always #8.5 xtal_clk = ~xtal_clk;

  function automatic logic [15:0] mk(input int a, input int b);
    return {b[10:0], a[4:0]};
  endfunction

  always @(posedge osc_clk) begin
    if (rst_n) begin
      int a, b;
      a = int'(prog_word[4:0]);
      b = int'(prog_word[15:5]);
      if (a > b) err_m = 1'b1;
      if (k == n_cur - 1) begin
        k = 0;
        if (a <= b) n_cur = 32 * (b + 1) + a;
      end else begin
        k = k + 1;
      end
    end
  end

  always @(posedge xtal_clk) begin
    if (rst_n) begin
      if (j == r_cur) begin
        j = 0;
        r_cur = int'(ref_div);
      end else begin
        j = j + 1;
      end
    end
  end

  always @(negedge osc_clk) begin
    logic es;
    es = rst_n && (k == n_cur - 1);
    vectors++;
    if (syn_pulse !== es) begin
      fails++;
      $display("FAIL %s syn_pulse got %b exp %b at %0t", osc_tag, syn_pulse, es, $time);
    end
    vectors++;
    if (prog_err !== err_m) begin
      fails++;
      $display("FAIL %s prog_err got %b exp %b at %0t", osc_tag, prog_err, err_m, $time);
    end
  end

  always @(negedge xtal_clk) begin
    logic er;
    er = rst_n && (j == r_cur);
    vectors++;
    if (ref_pulse !== er) begin
      fails++;
      $display("FAIL %s ref_pulse got %b exp %b at %0t", ref_tag, ref_pulse, er, $time);
    end
  end

  task automatic osc_wait(input int n);
    repeat (n) @(posedge osc_clk);
    #1;
  endtask

  task automatic xtal_wait(input int n);
    repeat (n) @(posedge xtal_clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got running exp finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    fork
      begin
        // R8: outputs quiet while reset is held
        prog_word = mk(5, 10);
        osc_wait(10);
        // R3: first period of 32 cycles, then A=5,B=10 (357 cycles)
        osc_tag = "R3";
        rst_n = 1'b1;
        osc_wait(32 + 2 * 357 + 20);
        // R1, R2: large swallow value
        osc_tag = "R1,R2";
        prog_word = mk(31, 40);
        osc_wait(3000);
        prog_word = mk(31, 31);
        osc_wait(2200);
        // R4: changes inside a period take effect only at its end
        osc_tag = "R4";
        prog_word = mk(0, 3);
        osc_wait(50);
        prog_word = mk(1, 1);
        osc_wait(300);
        // R5: illegal pair kept out, flag sticky
        osc_tag = "R5";
        prog_word = mk(7, 3);
        osc_wait(200);
        prog_word = mk(2, 2);
        osc_wait(400);
      end
      begin
        ref_div = 10'd4;
        wait (rst_n);
        // R7: first reference period is 2 cycles, then R=4
        ref_tag = "R7";
        xtal_wait(30);
        // R6: divide by 10 and by 1
        ref_tag = "R6";
        ref_div = 10'd9;
        xtal_wait(60);
        ref_div = 10'd0;
        xtal_wait(20);
        // R7: mid-period changes adopted only at the pulse
        ref_tag = "R7";
        ref_div = 10'd12;
        xtal_wait(5);
        ref_div = 10'd3;
        xtal_wait(7);
        ref_div = 10'd6;
        xtal_wait(80);
      end
    join
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule